// File: doc/BRIEF.md
# Modem Line Status Change Detector

This block monitors four asynchronous modem handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. Each input goes through a two-flop synchroniser. The block then compares the synchronised value with the value it held one cycle earlier. When it finds a qualifying transition, it latches a sticky change flag for that line. On clear-to-send, data-set-ready and carrier detect, any level change qualifies. On ring indicator, only a low-to-high transition counts.

The block presents an eight-bit status word. The lower nibble holds the sticky change flags and the upper nibble holds the current synchronised line levels. A status read strobe clears the flags. It also clears the interrupt request, which is the OR of the flags gated by an enable input. This request is the lowest-priority interrupt source of a serial port, and priority arbitration against the other sources happens outside the block.

Top module: `mdm_stat_top`

## Requirements
- R1: After reset, status_o is 8'h00 and irq_o is 0.
- R2: Three cycles after any level change on cts_i, the change flag status_o[0] is 1. It stays at 1 until a read clears it.
- R3: Three cycles after any level change on dsr_i, status_o[1] is 1. Three cycles after any level change on dcd_i, status_o[3] is 1.
- R4: Three cycles after a low-to-high change on ri_i, status_o[2] is 1. A high-to-low change on ri_i leaves status_o[2] unchanged.
- R5: status_o[7:4] reflects the synchronised levels of {dcd_i, ri_i, dsr_i, cts_i}, two cycles after each input changes.
- R6: A cycle with rd_i high clears every flag in status_o[3:0] at the next clock edge, unless that flag has a new qualifying edge detected in the same cycle, in which case the flag stays 1.
- R7: irq_o equals ien_i AND the OR of status_o[3:0]. It is combinational, so it falls together with the flags after a read and responds to ien_i without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring indicator line, asynchronous |
| dcd_i | input | 1 | Carrier detect line, asynchronous |
| rd_i | input | 1 | Status read strobe, one cycle per read |
| ien_i | input | 1 | Modem interrupt enable |
| status_o | output | 8 | [3:0] change flags (cts, dsr, ri rise, dcd), [7:4] line levels |
| irq_o | output | 1 | Modem status interrupt request |

## Verification
A line change sampled at one clock edge shows up in the level field two edges later and in the change flag three edges later. A read strobe clears the flags at the edge that follows it. irq_o follows the flags and ien_i in the same cycle.

The bench keeps a cycle-accurate reference model. The model is a shadow of the two synchroniser stages, the previous-value stage and the flags, and it advances in step with the design's clock edges. Outputs are compared at the falling clock edge. Random line toggles and reads are mixed with directed cases: a ring-indicator fall, and a read that lands in the same cycle as a detected edge.

// File: rtl/mdm_stat_pkg.sv
package mdm_stat_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned LINE_CTS = 0;
  localparam int unsigned LINE_DSR = 1;
  localparam int unsigned LINE_RI  = 2;
  localparam int unsigned LINE_DCD = 3;
  typedef enum logic {EDGE_ANY = 1'b0, EDGE_RISE = 1'b1} edge_mode_e;
  typedef logic [NUM_LINES-1:0] line_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_edge_det.sv
module mdm_edge_det #(
  parameter mdm_stat_pkg::edge_mode_e MODE = mdm_stat_pkg::EDGE_ANY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  generate
    if (MODE == mdm_stat_pkg::EDGE_RISE) begin : g_rise
      assign hit_o = lvl_i & ~prev_q;
    end else begin : g_any
      assign hit_o = lvl_i ^ prev_q;
    end
  endgenerate
endmodule

// File: rtl/mdm_delta_reg.sv
module mdm_delta_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] hit_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] flag_q;

  // new edge wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (clr_i ? '0 : flag_q) | hit_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mdm_stat_top.sv
module mdm_stat_top
  import mdm_stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  input  logic       rd_i,
  input  logic       ien_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  line_vec_t raw, lvl, hit, flag;

  assign raw = {dcd_i, ri_i, dsr_i, cts_i};

  mdm_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(raw), .sync_o(lvl)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_det
    localparam edge_mode_e M = (g == LINE_RI) ? EDGE_RISE : EDGE_ANY;
    mdm_edge_det #(.MODE(M)) u_det (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl[g]), .hit_o(hit[g])
    );
  end

  mdm_delta_reg #(.WIDTH(NUM_LINES)) u_delta (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .clr_i(rd_i), .flag_o(flag)
  );

  assign status_o = {lvl, flag};
  assign irq_o    = ien_i & (|flag);
endmodule

// File: rtl/mdm_stat_chk.sv
module mdm_stat_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic       ien_i,
  input logic [7:0] status_o,
  input logic       irq_o
);
  a_r7_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ien_i && (status_o[3:0] != 4'h0)));

  a_r2_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && status_o[0]) |=> status_o[0]);

  a_r4_ri_no_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[2] && !status_o[6]) |=> !status_o[2]);

  a_r3_dsr_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[5] != $past(status_o[5])) |=> status_o[1]);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && $stable(status_o[7:4])) |=> (status_o[3:0] == 4'h0) || $changed(status_o[7:4]));
endmodule

bind mdm_stat_top mdm_stat_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .ien_i(ien_i),
  .status_o(status_o), .irq_o(irq_o)
);

// File: tb/mdm_stat_top_test.sv
module mdm_stat_top_test;
  logic clk = 0, rst_ni = 0;
  logic cts = 0, dsr = 0, ri = 0, dcd = 0, rd = 0, ien = 0;
  logic [7:0] status;
  logic irq;
  int checks = 0, errors = 0;
  logic [3:0] s1 = 0, s2 = 0, pv = 0, fl = 0;

  mdm_stat_top uut (.clk_i(clk), .rst_ni(rst_ni), .cts_i(cts), .dsr_i(dsr),
    .ri_i(ri), .dcd_i(dcd), .rd_i(rd), .ien_i(ien), .status_o(status), .irq_o(irq));

  always #10 clk = ~clk;

  function automatic logic [3:0] hits(logic [3:0] cur, logic [3:0] prv);
    logic [3:0] h;
    h = cur ^ prv;
    h[2] = cur[2] & ~prv[2];
    return h;
  endfunction

  always @(posedge clk) if (rst_ni) begin
    fl <= (rd ? 4'h0 : fl) | hits(s2, pv);
    pv <= s2;
    s2 <= s1;
    s1 <= {dcd, ri, dsr, cts};
  end

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(string req);
    @(negedge clk);
    chk(req, {irq, status}, {ien & (|fl), s2, fl});
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", {irq, status}, 9'h000);
    rst_ni = 1; ien = 1;
    step("R1");
    // directed: cts rise, flag at 3 cycles
    cts = 1;
    step("R2"); step("R5"); step("R2");
    chk("R2", {8'h0, status[0]}, 9'h1);
    step("R2");
    rd = 1; step("R6"); rd = 0; step("R6");
    chk("R7", {8'h0, irq}, 9'h0);
    // ri rise then fall
    ri = 1; repeat (4) step("R4");
    rd = 1; step("R6"); rd = 0;
    ri = 0; repeat (4) step("R4");
    chk("R4", {8'h0, status[2]}, 9'h0);
    // dsr and dcd
    dsr = 1; dcd = 1; repeat (4) step("R3");
    chk("R3", {8'h0, status[3], 2'b0, status[1]}, 9'h009);
    ien = 0; step("R7"); ien = 1; step("R7");
    rd = 1; step("R6"); rd = 0; step("R6");
    // read coinciding with detection: flag must survive
    cts = 0; step("R6"); step("R6");
    rd = 1; step("R6"); rd = 0;
    chk("R6", {8'h0, status[0]}, 9'h1);
    step("R6");
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) cts = ~cts;
      if (r[7:4] == 0) dsr = ~dsr;
      if (r[11:8] == 0) ri = ~ri;
      if (r[15:12] == 0) dcd = ~dcd;
      rd = (r[19:16] == 0);
      ien = (r[23:20] != 0);
      step(i % 2 ? "R2" : "R5");
    end
    rd = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule